// File: doc/BRIEF.md
# Interrupt Message Forwarder

This block sits behind an interrupt source register file and turns sources that are both enabled and pending into outgoing interrupt messages. It reads the enable bits, the pending bits and the per-source target words, all held outside it, together with a domain-wide enable bit. Each message carries three fields: a hart index, a guest index and an interrupt identity, all taken from the chosen source's target word. In the same cycle that a message is loaded into the output register, the block raises a clear strobe that names the source, so the pending bit is dropped in the same step as the message goes out.

Three kinds of request start work. The first is a pulse that marks an accepted register write; it starts a full pass over sources 1 to NSRC-1 in ascending order. The second is an input event on one source; it checks only that source. The third is a write to the block's own generate-message register; this sends one message straight away, with the guest index forced to zero, and is then followed by a full pass. The controller has four states. IDLE picks the next request, in the priority order generate, then pass, then event. GEN waits for a free output slot and sends the generated message, then returns to IDLE. SCAN walks the source index upward and moves to IDLE after the last source. CHECK examines one event source and then moves to IDLE. SCAN and CHECK hold their index while a source hits and the output slot is occupied.

Top module: `irq_msg_fwd`

## Requirements
- R1: After reset msg_valid and clr_valid are 0 and gen_q reads 0.
- R2: While dom_ie is 0 no source message is sent and no clear strobe is raised, even when a pass runs over sources that are enabled and pending.
- R3: A source is forwarded only when its enable and pending bits are both 1. clr_valid pulses with clr_idx naming that source in the same cycle the message is loaded, so after a pass the pending vector equals its old value with every enabled bit removed.
- R4: Message fields come from the source's target word: hart = bits 31:18, guest = bits 17:12, identity = bits 10:0. Bit 11 has no effect on the message.
- R5: A wr_done pulse starts a pass that visits sources 1 to NSRC-1 in ascending order, so messages leave in ascending source order. Source 0 is never forwarded.
- R6: An evt_valid pulse with evt_idx = k checks source k alone, and it is given after k's pending bit has been updated. Other pending sources stay pending. A pending bit that becomes set without any trigger sends nothing.
- R7: A gen_we write stores gen_wdata with bits 17:12 cleared into gen_q. It sends one message with hart = bits 31:18, guest = 0 and identity = bits 10:0, whatever the value of dom_ie. That message comes before the messages of the pass that the write also starts.
- R8: While msg_valid is 1 and msg_ready is 0, the message and its fields hold still. The pass stalls, so it clears no further pending bit, and at most one message is loaded per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dom_ie | input | 1 | Domain interrupt enable |
| src_en | input | NSRC | Per-source enable bits |
| src_pend | input | NSRC | Per-source pending bits |
| src_tgt | input | NSRC*32 | Per-source target words, source k at bits k*32 +: 32 |
| wr_done | input | 1 | Pulse: a register write was accepted |
| evt_valid | input | 1 | Pulse: input event on one source |
| evt_idx | input | IDXW | Source index of the event |
| gen_we | input | 1 | Write strobe of the generate-message register |
| gen_wdata | input | 32 | Generate-message write data |
| gen_q | output | 32 | Stored generate-message value |
| clr_valid | output | 1 | Pending-clear strobe |
| clr_idx | output | IDXW | Source whose pending bit is to clear |
| msg_valid | output | 1 | Message valid |
| msg_ready | input | 1 | Message accepted by the sink |
| msg_hart | output | 14 | Message hart index |
| msg_guest | output | 6 | Message guest index |
| msg_eiid | output | 11 | Message interrupt identity |

## Verification
The assertions rely on two things about the surrounding register file. It applies clr_idx to its pending vector at the same clock edge as the strobe. It keeps src_en and src_tgt stable while a pass is running. The bench models that register file itself. It changes enables and targets only between passes, which it spaces out with long idle gaps. It changes pending bits only through a one-cycle set or clear request. The sink's ready signal is held high, held low, or drawn at random from a fixed seed, so the stall path is exercised under both directed and random back-pressure.

// File: rtl/imf_pkg.sv
package imf_pkg;
    localparam int HART_W    = 14;
    localparam int GUEST_W   = 6;
    localparam int EIID_W    = 11;
    localparam int HART_LSB  = 18;
    localparam int GUEST_LSB = 12;
    localparam logic [31:0] GUEST_MASK = ((32'd1 << GUEST_W) - 32'd1) << GUEST_LSB;

    typedef enum logic [1:0] {ST_IDLE, ST_GEN, ST_SCAN, ST_CHECK} imf_state_e;

    typedef struct packed {
        logic [HART_W-1:0]  hart;
        logic [GUEST_W-1:0] guest;
        logic [EIID_W-1:0]  eiid;
    } imf_msg_t;

    function automatic imf_msg_t tgt_to_msg(input logic [31:0] t);
        imf_msg_t m;
        m.hart  = t[HART_LSB +: HART_W];
        m.guest = t[GUEST_LSB +: GUEST_W];
        m.eiid  = t[EIID_W-1:0];
        return m;
    endfunction
endpackage

// File: rtl/imf_req_track.sv
module imf_req_track
    import imf_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int IDXW = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_done,
    input  logic            evt_valid,
    input  logic [IDXW-1:0] evt_idx,
    input  logic            gen_we,
    input  logic [31:0]     gen_wdata,
    input  logic            take_scan,
    input  logic            take_evt,
    input  logic            take_gen,
    output logic            scan_req,
    output logic            evt_any,
    output logic [IDXW-1:0] evt_pick,
    output logic            gen_req,
    output logic [31:0]     gen_q
);
    logic [NSRC-1:0] evt_map;
    logic [NSRC-1:0] set_mask;
    logic [NSRC-1:0] pick_mask;

    always_comb begin
        set_mask = '0;
        if (evt_valid && evt_idx != '0 && 32'(evt_idx) < NSRC)
            set_mask[evt_idx] = 1'b1;
    end

    always_comb begin
        evt_pick = '0;
        for (int k = NSRC - 1; k >= 1; k--)
            if (evt_map[k]) evt_pick = IDXW'(k);
    end

    assign evt_any   = |evt_map;
    assign pick_mask = take_evt ? (NSRC'(1) << evt_pick) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_map  <= '0;
            scan_req <= 1'b0;
            gen_req  <= 1'b0;
            gen_q    <= '0;
        end else begin
            evt_map  <= (evt_map & ~pick_mask) | set_mask;
            scan_req <= (scan_req && !take_scan) || wr_done || gen_we;
            gen_req  <= (gen_req && !take_gen) || gen_we;
            if (gen_we) gen_q <= gen_wdata & ~GUEST_MASK;
        end
    end
endmodule

// File: rtl/imf_ctrl.sv
module imf_ctrl
    import imf_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int IDXW = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dom_ie,
    input  logic [NSRC-1:0] src_en,
    input  logic [NSRC-1:0] src_pend,
    input  logic            scan_req,
    input  logic            evt_any,
    input  logic [IDXW-1:0] evt_pick,
    input  logic            gen_req,
    input  logic            slot_free,
    output logic            take_scan,
    output logic            take_evt,
    output logic            take_gen,
    output logic            issue_src,
    output logic            load_gen,
    output logic [IDXW-1:0] cur_idx
);
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NSRC - 1);

    imf_state_e      state, state_n;
    logic [IDXW-1:0] idx_n;
    logic            hit;

    assign hit = dom_ie && src_en[cur_idx] && src_pend[cur_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cur_idx <= '0;
        end else begin
            state   <= state_n;
            cur_idx <= idx_n;
        end
    end

    always_comb begin
        state_n   = state;
        idx_n     = cur_idx;
        take_scan = 1'b0;
        take_evt  = 1'b0;
        take_gen  = 1'b0;
        issue_src = 1'b0;
        load_gen  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (gen_req) begin
                    state_n = ST_GEN;
                end else if (scan_req) begin
                    take_scan = 1'b1;
                    idx_n     = IDXW'(1);
                    state_n   = ST_SCAN;
                end else if (evt_any) begin
                    take_evt = 1'b1;
                    idx_n    = evt_pick;
                    state_n  = ST_CHECK;
                end
            end
            ST_GEN: begin
                if (slot_free) begin
                    load_gen = 1'b1;
                    take_gen = 1'b1;
                    state_n  = ST_IDLE;
                end
            end
            ST_SCAN: begin
                if (!(hit && !slot_free)) begin
                    issue_src = hit;
                    if (cur_idx == LAST_IDX) state_n = ST_IDLE;
                    else                     idx_n   = cur_idx + IDXW'(1);
                end
            end
            ST_CHECK: begin
                if (!(hit && !slot_free)) begin
                    issue_src = hit;
                    state_n   = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/imf_msg_reg.sv
module imf_msg_reg
    import imf_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     issue_src,
    input  logic     load_gen,
    input  imf_msg_t src_msg,
    input  imf_msg_t gen_msg,
    input  logic     msg_ready,
    output logic     msg_valid,
    output imf_msg_t msg_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            msg_q     <= '0;
        end else if (load_gen || issue_src) begin
            msg_valid <= 1'b1;
            msg_q     <= load_gen ? gen_msg : src_msg;
        end else if (msg_ready) begin
            msg_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_msg_fwd.sv
module irq_msg_fwd
    import imf_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int IDXW = $clog2(NSRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dom_ie,
    input  logic [NSRC-1:0]    src_en,
    input  logic [NSRC-1:0]    src_pend,
    input  logic [NSRC*32-1:0] src_tgt,
    input  logic               wr_done,
    input  logic               evt_valid,
    input  logic [IDXW-1:0]    evt_idx,
    input  logic               gen_we,
    input  logic [31:0]        gen_wdata,
    output logic [31:0]        gen_q,
    output logic               clr_valid,
    output logic [IDXW-1:0]    clr_idx,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [HART_W-1:0]  msg_hart,
    output logic [GUEST_W-1:0] msg_guest,
    output logic [EIID_W-1:0]  msg_eiid
);
    logic            scan_req, evt_any, gen_req;
    logic [IDXW-1:0] evt_pick, cur_idx;
    logic            take_scan, take_evt, take_gen;
    logic            issue_src, load_gen, slot_free;
    imf_msg_t        src_msg, gen_msg, msg_q;

    assign slot_free = !msg_valid || msg_ready;
    assign src_msg   = tgt_to_msg(src_tgt[cur_idx*32 +: 32]);
    always_comb begin
        gen_msg       = tgt_to_msg(gen_q);
        gen_msg.guest = '0;
    end

    imf_req_track #(.NSRC(NSRC), .IDXW(IDXW)) u_req (
        .clk(clk), .rst_n(rst_n), .wr_done(wr_done),
        .evt_valid(evt_valid), .evt_idx(evt_idx),
        .gen_we(gen_we), .gen_wdata(gen_wdata),
        .take_scan(take_scan), .take_evt(take_evt), .take_gen(take_gen),
        .scan_req(scan_req), .evt_any(evt_any), .evt_pick(evt_pick),
        .gen_req(gen_req), .gen_q(gen_q)
    );

    imf_ctrl #(.NSRC(NSRC), .IDXW(IDXW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .dom_ie(dom_ie),
        .src_en(src_en), .src_pend(src_pend),
        .scan_req(scan_req), .evt_any(evt_any), .evt_pick(evt_pick),
        .gen_req(gen_req), .slot_free(slot_free),
        .take_scan(take_scan), .take_evt(take_evt), .take_gen(take_gen),
        .issue_src(issue_src), .load_gen(load_gen), .cur_idx(cur_idx)
    );

    imf_msg_reg u_msg (
        .clk(clk), .rst_n(rst_n), .issue_src(issue_src), .load_gen(load_gen),
        .src_msg(src_msg), .gen_msg(gen_msg), .msg_ready(msg_ready),
        .msg_valid(msg_valid), .msg_q(msg_q)
    );

    assign clr_valid = issue_src;
    assign clr_idx   = cur_idx;
    assign msg_hart  = msg_q.hart;
    assign msg_guest = msg_q.guest;
    assign msg_eiid  = msg_q.eiid;
endmodule

// File: rtl/imf_chk.sv
module imf_chk
    import imf_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int IDXW = $clog2(NSRC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               dom_ie,
    input logic [NSRC-1:0]    src_en,
    input logic [NSRC-1:0]    src_pend,
    input logic [NSRC*32-1:0] src_tgt,
    input logic               gen_we,
    input logic [31:0]        gen_wdata,
    input logic [31:0]        gen_q,
    input logic               clr_valid,
    input logic [IDXW-1:0]    clr_idx,
    input logic               msg_valid,
    input logic               msg_ready,
    input logic [HART_W-1:0]  msg_hart,
    input logic [GUEST_W-1:0] msg_guest,
    input logic [EIID_W-1:0]  msg_eiid
);
    imf_msg_t sel;
    assign sel = tgt_to_msg(src_tgt[clr_idx*32 +: 32]);

    // R2
    dom_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_valid |-> dom_ie);

    // R3
    enpend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_valid |-> (src_en[clr_idx] && src_pend[clr_idx]));

    // R4
    clr_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_valid |=> (msg_valid && msg_hart == $past(sel.hart)
                       && msg_guest == $past(sel.guest) && msg_eiid == $past(sel.eiid)));

    // R5
    no_src0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_valid |-> (clr_idx != '0));

    // R7
    gen_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gen_we |=> (gen_q[GUEST_LSB +: GUEST_W] == '0
                    && gen_q[HART_LSB +: HART_W] == $past(gen_wdata[HART_LSB +: HART_W])));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_hart)
                                       && $stable(msg_guest) && $stable(msg_eiid)));
endmodule

bind irq_msg_fwd imf_chk #(.NSRC(NSRC), .IDXW(IDXW)) u_imf_chk (
    .clk(clk), .rst_n(rst_n), .dom_ie(dom_ie), .src_en(src_en),
    .src_pend(src_pend), .src_tgt(src_tgt), .gen_we(gen_we),
    .gen_wdata(gen_wdata), .gen_q(gen_q), .clr_valid(clr_valid),
    .clr_idx(clr_idx), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_hart(msg_hart), .msg_guest(msg_guest), .msg_eiid(msg_eiid)
);

// File: tb/irq_msg_fwd_tb.sv
module irq_msg_fwd_tb;
    localparam int NSRC = 8;
    localparam int IDXW = 3;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic               rst_n = 1'b0;
    logic               dom_ie = 1'b0;
    logic [NSRC-1:0]    en = '0;
    logic [NSRC-1:0]    pend;
    logic [NSRC*32-1:0] tgt = '0;
    logic               wr_done = 1'b0, evt_valid = 1'b0, gen_we = 1'b0;
    logic [IDXW-1:0]    evt_idx = '0;
    logic [31:0]        gen_wdata = '0;
    logic [31:0]        gen_q;
    logic               clr_valid, msg_valid;
    logic               msg_ready;
    logic [IDXW-1:0]    clr_idx;
    logic [13:0]        msg_hart;
    logic [5:0]         msg_guest;
    logic [10:0]        msg_eiid;

    logic [NSRC-1:0] set_req = '0, bclr_req = '0;
    int rdy_mode = 0;
    int checks = 0, fails = 0;
    int rx_n = 0;
    logic [31:0] rx_w [0:255];
    logic [31:0] exp_w [0:63];
    int exp_n;

    irq_msg_fwd #(.NSRC(NSRC)) u_dut (
        .clk(clk), .rst_n(rst_n), .dom_ie(dom_ie), .src_en(en), .src_pend(pend),
        .src_tgt(tgt), .wr_done(wr_done), .evt_valid(evt_valid), .evt_idx(evt_idx),
        .gen_we(gen_we), .gen_wdata(gen_wdata), .gen_q(gen_q),
        .clr_valid(clr_valid), .clr_idx(clr_idx), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_hart(msg_hart), .msg_guest(msg_guest),
        .msg_eiid(msg_eiid)
    );

    // register-file model of the pending bits
    always @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else pend <= (pend & ~(clr_valid ? (NSRC'(1) << clr_idx) : '0) & ~bclr_req) | set_req;
    end

    always @(posedge clk) begin
        if (rst_n && msg_valid && msg_ready) begin
            rx_w[rx_n[7:0]] <= {1'b0, msg_hart, msg_guest, msg_eiid};
            rx_n <= rx_n + 1;
        end
    end

    always @(negedge clk) begin
        case (rdy_mode)
            0:       msg_ready <= 1'b1;
            1:       msg_ready <= 1'b0;
            default: msg_ready <= ($urandom % 3) != 0;
        endcase
    end

    function automatic logic [31:0] exp_of(input logic [31:0] t);
        return {1'b0, t[31:18], t[17:12], t[10:0]};
    endfunction

    function automatic logic [31:0] exp_gen(input logic [31:0] v);
        return {1'b0, v[31:18], 6'd0, v[10:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pend(input logic [NSRC-1:0] m);
        set_req = m; tick(1); set_req = '0;
    endtask

    task automatic clear_pend();
        bclr_req = '1; tick(1); bclr_req = '0;
    endtask

    task automatic pulse_wr();
        wr_done = 1'b1; tick(1); wr_done = 1'b0;
    endtask

    task automatic pulse_gen(input logic [31:0] v);
        gen_wdata = v; gen_we = 1'b1; tick(1); gen_we = 1'b0;
    endtask

    task automatic pulse_evt(input int k);
        evt_idx = IDXW'(k); evt_valid = 1'b1; tick(1); evt_valid = 1'b0;
    endtask

    task automatic add_scan_exp();
        for (int k = 1; k < NSRC; k++)
            if (en[k] && pend[k]) begin
                exp_w[exp_n] = exp_of(tgt[k*32 +: 32]);
                exp_n++;
            end
    endtask

    task automatic cmp_stream(input int base, input string req, input string what);
        chk(rx_n - base == exp_n, req, {what, " count"}, 32'(rx_n - base), 32'(exp_n));
        for (int i = 0; i < exp_n && i < rx_n - base; i++)
            chk(rx_w[base + i] == exp_w[i], req, {what, " word"}, rx_w[base + i], exp_w[i]);
    endtask

    initial begin
        int base;
        logic [NSRC-1:0] old_p;
        logic [31:0] v;
        void'($urandom(32'd1957));
        for (int k = 0; k < NSRC; k++)
            tgt[k*32 +: 32] = {14'(k * 3 + 1), 6'(k + 2), 1'b1, 11'(k + 100)};
        tick(4);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk(msg_valid == 0, "R1", "msg_valid", 32'(msg_valid), 0);
        chk(clr_valid == 0, "R1", "clr_valid", 32'(clr_valid), 0);
        chk(gen_q == 0, "R1", "gen_q", gen_q, 0);

        // R2 domain disabled: pass sends nothing and clears nothing
        en = 8'hFE; set_pend(8'h2A); base = rx_n;
        pulse_wr(); tick(30);
        chk(rx_n == base, "R2", "msgs while off", 32'(rx_n - base), 0);
        chk(pend == 8'h2A, "R2", "pend kept", 32'(pend), 32'h2A);
        // R6 enable change alone triggers nothing
        dom_ie = 1'b1; tick(20);
        chk(rx_n == base, "R6", "no trigger", 32'(rx_n - base), 0);
        // R5 then a pass forwards 1,3,5 in order
        exp_n = 0; add_scan_exp(); pulse_wr(); tick(30);
        cmp_stream(base, "R5", "ordered pass");
        chk(pend == 8'h00, "R3", "pend cleared", 32'(pend), 0);

        // R6 event checks only its own source
        clear_pend(); set_pend(8'h28); base = rx_n; tick(10);
        chk(rx_n == base, "R6", "pend w/o event", 32'(rx_n - base), 0);
        pulse_evt(5); tick(10);
        exp_n = 1; exp_w[0] = exp_of(tgt[5*32 +: 32]);
        cmp_stream(base, "R6", "event msg");
        chk(pend == 8'h08, "R6", "other pend kept", 32'(pend), 32'h08);
        // R3 disabled source is not forwarded on event
        en[3] = 1'b0; base = rx_n; pulse_evt(3); tick(10);
        chk(rx_n == base, "R3", "disabled src", 32'(rx_n - base), 0);
        chk(pend == 8'h08, "R3", "disabled pend kept", 32'(pend), 32'h08);

        // R8 back-pressure stalls the pass
        clear_pend(); en = 8'hFE; set_pend(8'h54); rdy_mode = 1; tick(2);
        base = rx_n; pulse_wr(); tick(15);
        chk(msg_valid == 1, "R8", "valid held", 32'(msg_valid), 1);
        chk({1'b0, msg_hart, msg_guest, msg_eiid} == exp_of(tgt[2*32 +: 32]), "R8",
            "held fields", {1'b0, msg_hart, msg_guest, msg_eiid}, exp_of(tgt[2*32 +: 32]));
        chk(pend == 8'h50, "R8", "one cleared", 32'(pend), 32'h50);
        exp_n = 0;
        for (int k = 2; k < NSRC; k += 2) begin exp_w[exp_n] = exp_of(tgt[k*32 +: 32]); exp_n++; end
        rdy_mode = 0; tick(20);
        cmp_stream(base, "R8", "drained");

        // R7 generate with domain off, then with domain on
        clear_pend(); dom_ie = 1'b0; set_pend(8'h0A); base = rx_n;
        v = 32'hA5A5_F7FF; pulse_gen(v); tick(20);
        chk(gen_q == (v & ~32'h0003F000), "R7", "gen_q", gen_q, v & ~32'h0003F000);
        exp_n = 1; exp_w[0] = exp_gen(v);
        cmp_stream(base, "R7", "gen while off");
        chk(pend == 8'h0A, "R7", "pend kept", 32'(pend), 32'h0A);
        dom_ie = 1'b1; base = rx_n; v = 32'h3C3F_FC55;
        exp_n = 1; exp_w[0] = exp_gen(v); add_scan_exp();
        pulse_gen(v); tick(30);
        cmp_stream(base, "R7", "gen then pass");

        // R3 R4 R5 random passes with random ready
        for (int it = 0; it < 20; it++) begin
            clear_pend();
            en = NSRC'($urandom) & 8'hFE;
            for (int k = 0; k < NSRC; k++) tgt[k*32 +: 32] = $urandom;
            set_pend(NSRC'($urandom) & 8'hFE);
            old_p = pend; rdy_mode = 2;
            exp_n = 0; add_scan_exp(); base = rx_n;
            pulse_wr(); tick(80);
            rdy_mode = 0; tick(10);
            cmp_stream(base, "R4", "random pass");
            chk(pend == (old_p & ~en), "R3", "random pend", 32'(pend), 32'(old_p & ~en));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule